// File: doc/BRIEF.md
# Sampling-Phase Acquisition Unit

This unit estimates how far the receiver's ADC sampling instant sits from its best position when a packet arrives. It drives a measurement over two consecutive short-training symbols. An external frequency-domain correlation engine returns three powers for each symbol: the power at the detected cyclic shift, the power one shift late and the power one shift early. The first symbol is taken at the current sampling phase. The unit then asks the multiphase clock manager to move by half a clock period, and the second symbol is taken at that new phase.

The sign of the error comes from the first symbol: the error is positive when the late neighbour correlates more strongly than the early one, and negative otherwise. The gap between the centre power and the late-neighbour power is used as the measure. For a positive error it comes from the first symbol and is compared against a reference power. For a negative error it comes from the second symbol and is scaled by that same reference. A restoring divider that takes several cycles turns the ratio into phase steps of one sixteenth of a clock period. The result is rounded to the nearest step, clamped to half a period, and issued once as a signed command with a one-cycle strobe.

Top module: `phase_acq_top`

## Requirements
- R1: After reset, and whenever no acquisition is running, `busy`, `flip_req` and `corr_valid` are low. Reset clears `corr_steps` to 0, and a reset during an acquisition abandons it.
- R2: A `start` pulse in idle raises `busy` on the next cycle. The first accepted `meas_valid` is followed by `flip_req` high for exactly one cycle, and the unit then waits for the second measurement.
- R3: The error is positive when `pwr_late` is strictly greater than `pwr_early` in the first measurement. Otherwise, including equality, the error is negative or zero. The early power of the second measurement is not used.
- R4: For a positive error the magnitude is round(8·(I − min(max(C1−L1,0), I)) / I) steps. Here I is `ideal_pwr`, C1 is the first centre power and L1 is the first late power.
- R5: For a negative error the magnitude is round(8·min(max(C2−L2,0), I) / I) steps, using the second measurement's centre power C2 and late power L2.
- R6: Rounding is to the nearest step, and an exact half rounds away from zero.
- R7: The magnitude is clamped to 8 steps (half a clock period). A zero `ideal_pwr` gives the full 8 steps in the decided direction.
- R8: `corr_valid` is high for exactly one cycle per acquisition. It rises at most 23 cycles after the second measurement is accepted. `busy` falls on the following cycle. `corr_steps` changes only in the cycle in which `corr_valid` is high.
- R9: `meas_valid` is ignored in idle and while the division runs, and `start` is ignored while `busy` is high.
- R10: `corr_steps` is a two's-complement count of 1/16-period phase steps, 5 bits wide by default, so −8 is encoded as 5'b11000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an acquisition (pulse) |
| ideal_pwr | input | PWR_W | Reference power I at ideal phase |
| meas_valid | input | 1 | Correlation powers are valid this cycle |
| pwr_center | input | PWR_W | Power at the detected cyclic shift |
| pwr_late | input | PWR_W | Power at the next (later) cyclic shift |
| pwr_early | input | PWR_W | Power at the previous (earlier) cyclic shift |
| flip_req | output | 1 | Request a half-period phase advance |
| corr_valid | output | 1 | Correction command strobe |
| corr_steps | output | log2(STEPS_PER_CYCLE)+1 | Signed phase-step correction |
| busy | output | 1 | Acquisition in progress |

## Verification
The vector set pairs positive-error cases, decided by a stronger late neighbour, with negative-error cases decided by a stronger early neighbour or by equal powers. This separates the sign rule from the choice of which capture feeds the magnitude. A pair of ratios landing exactly on a half step and just below it tells round-to-nearest apart from truncation. Overflowing gaps, a centre below its neighbour and a zero reference exercise both clamps. One run injects unrelated powers and a start pulse while the division runs, to show that the latched capture alone decides the result.

// File: rtl/phase_acq_pkg.sv
package phase_acq_pkg;

    typedef enum logic [2:0] {
        PA_IDLE,
        PA_CAPT_A,
        PA_FLIP,
        PA_CAPT_B,
        PA_DIVIDE,
        PA_ISSUE
    } pa_state_e;

endpackage

// File: rtl/phase_acq_gap.sv
// Non-negative difference between a centre power and a neighbour power.
module phase_acq_gap #(
    parameter int PWR_W = 16
) (
    input  logic [PWR_W-1:0] centre,
    input  logic [PWR_W-1:0] neighbour,
    output logic [PWR_W-1:0] gap
);
    always_comb begin
        if (centre > neighbour) gap = centre - neighbour;
        else                    gap = '0;
    end
endmodule

// File: rtl/phase_acq_div.sv
// Restoring divider, one quotient bit per cycle, MSB first.
module phase_acq_div #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    localparam int REM_W = DEN_W + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } div_t;

    div_t             cur_q, nxt_d;
    logic [REM_W-1:0] shifted;
    logic [REM_W:0]   trial;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        shifted    = {cur_q.rem[REM_W-2:0], cur_q.quo[NUM_W-1]};
        trial      = {1'b0, shifted} - {2'b00, cur_q.den};
        if (go) begin
            nxt_d.rem = '0;
            nxt_d.quo = num;
            nxt_d.den = den;
            nxt_d.cnt = CNT_W'(NUM_W);
            nxt_d.run = 1'b1;
        end else if (cur_q.run) begin
            if (!trial[REM_W]) begin
                nxt_d.rem = trial[REM_W-1:0];
                nxt_d.quo = {cur_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                nxt_d.rem = shifted;
                nxt_d.quo = {cur_q.quo[NUM_W-2:0], 1'b0};
            end
            nxt_d.cnt = cur_q.cnt - 1'b1;
            if (cur_q.cnt == CNT_W'(1)) begin
                nxt_d.run  = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign quo  = cur_q.quo;
    assign done = cur_q.done;
endmodule

// File: rtl/phase_acq_quant.sv
// Clamps the rounded quotient to half a period and applies the sign.
module phase_acq_quant #(
    parameter int NUM_W  = 21,
    parameter int STEP_W = 5,
    parameter int HALF   = 8
) (
    input  logic [NUM_W-1:0]  quo,
    input  logic              negative,
    output logic [STEP_W-1:0] steps
);
    logic [STEP_W-1:0] mag;

    always_comb begin
        if (quo > NUM_W'(HALF)) mag = STEP_W'(HALF);
        else                    mag = quo[STEP_W-1:0];
        steps = negative ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/phase_acq_top.sv
module phase_acq_top #(
    parameter int PWR_W           = 16,
    parameter int STEPS_PER_CYCLE = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [PWR_W-1:0]                     ideal_pwr,
    input  logic                                 meas_valid,
    input  logic [PWR_W-1:0]                     pwr_center,
    input  logic [PWR_W-1:0]                     pwr_late,
    input  logic [PWR_W-1:0]                     pwr_early,
    output logic                                 flip_req,
    output logic                                 corr_valid,
    output logic [$clog2(STEPS_PER_CYCLE):0]     corr_steps,
    output logic                                 busy
);
    import phase_acq_pkg::*;

    localparam int LOG_STEPS = $clog2(STEPS_PER_CYCLE);
    localparam int HALF      = STEPS_PER_CYCLE / 2;
    localparam int STEP_W    = LOG_STEPS + 1;
    localparam int NUM_W     = PWR_W + LOG_STEPS + 1;
    localparam int DEN_W     = PWR_W + 1;

    typedef struct packed {
        pa_state_e         state;
        logic              pos;
        logic [PWR_W-1:0]  gap_a;
        logic [STEP_W-1:0] steps;
    } acq_t;

    acq_t              cur_q, nxt_d;
    logic [PWR_W-1:0]  gap_now;
    logic [PWR_W-1:0]  gap_a_lim;
    logic [PWR_W-1:0]  gap_b_lim;
    logic [PWR_W-1:0]  numer;
    logic [NUM_W-1:0]  div_num;
    logic [DEN_W-1:0]  div_den;
    logic [NUM_W-1:0]  div_quo;
    logic              div_go;
    logic              div_done;
    logic [STEP_W-1:0] q_steps;

    phase_acq_gap #(.PWR_W(PWR_W)) gap_i (
        .centre    (pwr_center),
        .neighbour (pwr_late),
        .gap       (gap_now)
    );

    // Numerator: positive error uses the first gap against the reference,
    // negative error uses the gap of the capture arriving now.
    always_comb begin
        gap_a_lim = (cur_q.gap_a > ideal_pwr) ? ideal_pwr : cur_q.gap_a;
        gap_b_lim = (gap_now > ideal_pwr) ? ideal_pwr : gap_now;
        numer     = cur_q.pos ? (ideal_pwr - gap_a_lim) : gap_b_lim;
        // round(HALF*N/I) = floor((2*HALF*N + I) / (2*I))
        div_num   = (NUM_W'(numer) << LOG_STEPS) + NUM_W'(ideal_pwr);
        div_den   = {ideal_pwr, 1'b0};
    end

    phase_acq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .done  (div_done)
    );

    phase_acq_quant #(.NUM_W(NUM_W), .STEP_W(STEP_W), .HALF(HALF)) quant_i (
        .quo      (div_quo),
        .negative (~cur_q.pos),
        .steps    (q_steps)
    );

    always_comb begin
        nxt_d  = cur_q;
        div_go = 1'b0;
        unique case (cur_q.state)
            PA_IDLE: begin
                if (start) nxt_d.state = PA_CAPT_A;
            end
            PA_CAPT_A: begin
                if (meas_valid) begin
                    nxt_d.pos   = (pwr_late > pwr_early);
                    nxt_d.gap_a = gap_now;
                    nxt_d.state = PA_FLIP;
                end
            end
            PA_FLIP: begin
                nxt_d.state = PA_CAPT_B;
            end
            PA_CAPT_B: begin
                if (meas_valid) begin
                    div_go      = 1'b1;
                    nxt_d.state = PA_DIVIDE;
                end
            end
            PA_DIVIDE: begin
                if (div_done) begin
                    nxt_d.steps = q_steps;
                    nxt_d.state = PA_ISSUE;
                end
            end
            PA_ISSUE: begin
                nxt_d.state = PA_IDLE;
            end
            default: nxt_d.state = PA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= PA_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flip_req   = (cur_q.state == PA_FLIP);
    assign corr_valid = (cur_q.state == PA_ISSUE);
    assign busy       = (cur_q.state != PA_IDLE);
    assign corr_steps = cur_q.steps;
endmodule

// File: rtl/phase_acq_chk.sv
module phase_acq_chk #(
    parameter int STEPS_PER_CYCLE = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             busy,
    input logic                             meas_valid,
    input logic                             flip_req,
    input logic                             corr_valid,
    input logic [$clog2(STEPS_PER_CYCLE):0] corr_steps
);
    localparam int HALF = STEPS_PER_CYCLE / 2;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!flip_req && !corr_valid));

    // R2
    flip_after_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip_req |-> ($past(meas_valid) && $past(busy)));

    // R2
    flip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip_req |=> !flip_req);

    // R8
    issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> (!corr_valid && !busy));

    // R8
    steps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_valid |-> $stable(corr_steps));

    // R7
    steps_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> ($signed(corr_steps) <= HALF && $signed(corr_steps) >= -HALF));
endmodule

bind phase_acq_top phase_acq_chk #(.STEPS_PER_CYCLE(STEPS_PER_CYCLE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .meas_valid (meas_valid),
    .flip_req   (flip_req),
    .corr_valid (corr_valid),
    .corr_steps (corr_steps)
);

// File: tb/phase_acq_top_tb_top.sv
module phase_acq_top_tb_top;
    localparam int PW    = 16;
    localparam int NW    = PW + 4 + 1;
    localparam int LIMIT = NW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] ideal_pwr = '0;
    logic          meas_valid = 1'b0;
    logic [PW-1:0] pwr_center = '0;
    logic [PW-1:0] pwr_late = '0;
    logic [PW-1:0] pwr_early = '0;
    logic          flip_req;
    logic          corr_valid;
    logic [4:0]    corr_steps;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    phase_acq_top #(.PWR_W(PW), .STEPS_PER_CYCLE(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ideal_pwr  (ideal_pwr),
        .meas_valid (meas_valid),
        .pwr_center (pwr_center),
        .pwr_late   (pwr_late),
        .pwr_early  (pwr_early),
        .flip_req   (flip_req),
        .corr_valid (corr_valid),
        .corr_steps (corr_steps),
        .busy       (busy)
    );

    typedef struct packed {
        logic [PW-1:0] ideal;
        logic [PW-1:0] c1;
        logic [PW-1:0] l1;
        logic [PW-1:0] e1;
        logic [PW-1:0] c2;
        logic [PW-1:0] l2;
        int            exp;
    } vec_t;

    // ideal, c1, l1, e1, c2, l2, expected steps
    localparam vec_t VECS [10] = '{
        '{16'd1000, 16'd1000, 16'd900, 16'd100, 16'd50,   16'd40,  7},  // R3 R4
        '{16'd1000, 16'd1000, 16'd200, 16'd100, 16'd900,  16'd10,  2},  // R4
        '{16'd1000, 16'd900,  16'd100, 16'd700, 16'd1000, 16'd400, -5}, // R3 R5
        '{16'd1600, 16'd1600, 16'd300, 16'd100, 16'd0,    16'd0,   2},  // R6 exact half
        '{16'd1600, 16'd500,  16'd100, 16'd400, 16'd799,  16'd500, -1}, // R6 below half
        '{16'd1000, 16'd200,  16'd10,  16'd90,  16'd3000, 16'd100, -8}, // R7 clamp
        '{16'd1000, 16'd500,  16'd800, 16'd100, 16'd20,   16'd10,  8},  // R7 centre below late
        '{16'd1000, 16'd700,  16'd300, 16'd300, 16'd800,  16'd550, -2}, // R3 equality
        '{16'd1000, 16'd1000, 16'd1,   16'd0,   16'd5,    16'd5,   0},  // R4 zero result
        '{16'd0,    16'd10,   16'd5,   16'd1,   16'd0,    16'd0,   8}   // R7 zero reference
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic run_acq(input vec_t v, input bit noise);
        int n;
        ideal_pwr = v.ideal;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        pwr_center = v.c1; pwr_late = v.l1; pwr_early = v.e1; meas_valid = 1'b1;
        @(negedge clk); meas_valid = 1'b0;
        check(flip_req == 1'b1, "R2 flip pulse", int'(flip_req), 1);
        @(negedge clk);
        check(flip_req == 1'b0, "R2 flip single", int'(flip_req), 0);
        // second capture: early power deliberately opposite to first (R3)
        pwr_center = v.c2; pwr_late = v.l2; pwr_early = v.e1 ^ 16'hFFFF; meas_valid = 1'b1;
        @(negedge clk); meas_valid = 1'b0;
        if (noise) begin // R9: these must not disturb the division
            pwr_center = 16'd7777; pwr_late = 16'd1; pwr_early = 16'd9000;
            meas_valid = 1'b1; start = 1'b1;
        end
        n = 0;
        while (!corr_valid && n < LIMIT + 2) begin
            @(negedge clk); n++;
        end
        meas_valid = 1'b0; start = 1'b0;
        check(corr_valid == 1'b1 && n <= LIMIT, "R8 strobe latency", n, LIMIT);
        check(int'($signed(corr_steps)) == v.exp, "R3 R4 R5 R6 R7 steps",
              int'($signed(corr_steps)), v.exp);
        @(negedge clk);
        check(corr_valid == 1'b0 && busy == 1'b0, "R8 single strobe",
              int'(corr_valid) + int'(busy), 0);
        check(int'($signed(corr_steps)) == v.exp, "R8 steps held",
              int'($signed(corr_steps)), v.exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && flip_req == 0 && corr_valid == 0 && corr_steps == 0,
              "R1 in reset", int'(busy) + int'(corr_steps), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && corr_steps == 0, "R1 after release", int'(busy), 0);

        // R9: measurements in idle are ignored
        meas_valid = 1'b1; pwr_center = 16'd500; pwr_late = 16'd10; pwr_early = 16'd1;
        repeat (2) @(negedge clk);
        meas_valid = 1'b0;
        check(busy == 0 && flip_req == 0 && corr_valid == 0, "R9 idle measurement",
              int'(busy) + int'(flip_req), 0);

        for (int i = 0; i < 10; i++) run_acq(VECS[i], 1'b0);

        // R10 encoding of -8
        run_acq(VECS[5], 1'b0);
        check(corr_steps == 5'b11000, "R10 encoding", int'(corr_steps), 24);

        // R9 noise during division, same expected result
        run_acq(VECS[2], 1'b1);

        // R8 idle hold
        repeat (5) @(negedge clk);
        check(int'($signed(corr_steps)) == -5, "R8 idle hold",
              int'($signed(corr_steps)), -5);

        // R1 reset during an acquisition
        ideal_pwr = 16'd1000;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        pwr_center = 16'd900; pwr_late = 16'd10; pwr_early = 16'd5; meas_valid = 1'b1;
        @(negedge clk); meas_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 0 && flip_req == 0 && corr_steps == 0, "R1 mid-run reset",
              int'(busy) + int'(corr_steps), 0);
        rst_n = 1'b1;
        repeat (NW + 4) @(negedge clk);
        check(corr_valid == 0 && busy == 0, "R1 abandoned run", int'(busy), 0);

        finish_run();
    end
endmodule